// File: doc/BRIEF.md
# E1 Fractional Timeslot Mapper

This block builds a serial E1 bit stream of 32 eight-bit slots per frame from a byte-wide payload source. A configuration gives a slot count and a first slot. The payload goes into that contiguous run of slots. The mode follows from the count. With all 32 slots the whole frame is payload and slot 0 gets no special treatment. With fewer than 32 slots the frame is structured: slot 0 is kept free for a separate overhead generator, and every slot outside the configured run carries a programmable idle byte.

The mapper keeps its own bit and slot position and emits one line bit per clock cycle. It asks for one payload byte per mapped slot through a ready/valid handshake. The request comes in the last bit time of the slot that comes before the mapped slot. A window strobe marks the eight bit times of slot 0 in structured mode, so that the overhead generator can put in its own bits. If the source has no byte ready when one is asked for, the block sends the idle byte and raises an underrun pulse. A configuration that names an impossible run is refused, and the settings already in force stay as they were.

Top module: `e1_slot_mapper`

## Requirements
- R1: A frame is 32 slots of 8 bits, sent most significant bit first, one bit per clock. In the first cycle after reset the output is slot 0, bit 7.
- R2: A slot count below 32 selects structured mode. In that mode slot 0 never takes a payload byte and carries the idle byte, and slot0_win is high for exactly the 8 bit times of slot 0.
- R3: A slot count of exactly 32 with first slot 0 selects transparent mode. Every slot, slot 0 included, takes a payload byte, and slot0_win stays low.
- R4: Slots outside the configured run carry the idle byte. After reset the idle byte is 0xFF.
- R5: With an unchanged configuration, pay_ready is asserted exactly slot-count times per frame. At one frame per 125 us this gives a payload rate of count x 64 kbps (24 slots give 1536 kbps).
- R6: The mapped slots are first, first+1, ..., first+count-1, and each carries the byte accepted for it. After reset the count is 24 and the first slot is 1.
- R7: A write is refused, and leaves count, first slot and idle byte unchanged, unless one of two things holds: count = 32 with first = 0, or 1 <= count <= 31 with first >= 1 and first + count <= 32.
- R8: pay_ready is high only during the last bit time of the slot just before a mapped slot. A byte is transferred when pay_valid and pay_ready are both high at a clock edge.
- R9: If pay_valid is low while pay_ready is high, the next slot carries the idle byte, and underrun is high for one cycle: the first bit time of that slot.
- R10: An accepted write takes effect from the next clock edge. The handshake and slot contents decided at the edge that ends the write cycle still follow the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_count | input | 6 | Requested slot count (0..63, only legal values are taken) |
| cfg_start | input | 5 | Requested first slot |
| cfg_idle | input | 8 | Requested idle byte |
| pay_valid | input | 1 | Payload byte offered |
| pay_data | input | 8 | Payload byte |
| pay_ready | output | 1 | Mapper takes a byte at this edge |
| ser_out | output | 1 | Serial E1 line bit |
| slot0_win | output | 1 | Slot-0 overhead window (structured mode only) |
| underrun | output | 1 | One-cycle pulse: mapped slot filled with idle |

## Verification
The bench builds the mapper with its default parameters: 32 slots of 8 bits, a reset configuration of 24 slots from slot 1, and an idle byte of 0xFF. These values cover the full 256-bit frame and the real E1 boundaries. That includes a run that ends exactly at slot 31, a single slot at 31, the switch between transparent and structured mode, and writes refused at every legality edge (count 0, count 33, a full frame not starting at 0, a structured run starting at 0, a run overflowing slot 31). Random configurations and source stall patterns then exercise underrun fill and writes arriving at any bit position of a frame.

// File: rtl/e1map_pkg.sv
package e1map_pkg;

  // Legal configurations: full frame from slot 0, or a partial run that
  // avoids slot 0 and does not pass the last slot.
  function automatic logic cfg_legal(input int unsigned slots,
                                     input int unsigned cnt,
                                     input int unsigned st);
    logic full_ok;
    logic part_ok;
    full_ok = (cnt == slots) && (st == 0);
    part_ok = (cnt >= 1) && (cnt < slots) && (st >= 1) && ((st + cnt) <= slots);
    return full_ok || part_ok;
  endfunction

endpackage

// File: rtl/e1map_pos.sv
module e1map_pos #(
  parameter int SLOTS     = 32,
  parameter int SLOT_BITS = 8,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [BIT_W-1:0]  bit_cnt,
  output logic [SLOT_W-1:0] slot_cnt,
  output logic [SLOT_W-1:0] next_slot,
  output logic              bit_last
);

  localparam logic [BIT_W-1:0]  BIT_TOP  = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_TOP = SLOT_W'(SLOTS - 1);

  logic [BIT_W-1:0]  bit_d;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    bit_last  = (bit_cnt == BIT_TOP);
    next_slot = (slot_cnt == SLOT_TOP) ? '0 : slot_cnt + 1'b1;
    bit_d     = bit_last ? '0 : bit_cnt + 1'b1;
    slot_d    = bit_last ? next_slot : slot_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      slot_cnt <= '0;
    end else begin
      bit_cnt  <= bit_d;
      slot_cnt <= slot_d;
    end
  end

  AST_SLOT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt != BIT_TOP) |=> (slot_cnt == $past(slot_cnt)));  // R1

endmodule

// File: rtl/e1map_cfg.sv
module e1map_cfg #(
  parameter int          SLOTS     = 32,
  parameter int          DEF_COUNT = 24,
  parameter int          DEF_START = 1,
  parameter logic [7:0]  IDLE_RST  = 8'hFF,
  localparam int         SLOT_W    = $clog2(SLOTS),
  localparam int         CNT_W     = $clog2(SLOTS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic [SLOT_W-1:0] wr_start,
  input  logic [7:0]        wr_idle,
  output logic [CNT_W-1:0]  count_q,
  output logic [SLOT_W-1:0] start_q,
  output logic [7:0]        idle_q,
  output logic              structured
);

  import e1map_pkg::*;

  logic              wr_ok;
  logic              upd_en;
  logic [CNT_W-1:0]  count_d;
  logic [SLOT_W-1:0] start_d;
  logic [7:0]        idle_d;

  always_comb begin
    wr_ok      = cfg_legal(SLOTS, int'(wr_count), int'(wr_start));
    upd_en     = wr && wr_ok;
    count_d    = upd_en ? wr_count : count_q;
    start_d    = upd_en ? wr_start : start_q;
    idle_d     = upd_en ? wr_idle  : idle_q;
    structured = (count_q < CNT_W'(SLOTS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= CNT_W'(DEF_COUNT);
      start_q <= SLOT_W'(DEF_START);
      idle_q  <= IDLE_RST;
    end else begin
      count_q <= count_d;
      start_q <= start_d;
      idle_q  <= idle_d;
    end
  end

  AST_CFG_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_legal(SLOTS, int'(count_q), int'(start_q)));  // R7

  AST_CFG_REFUSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wr_ok) |=> (count_q == $past(count_q) && start_q == $past(start_q)
                        && idle_q == $past(idle_q)));  // R7

endmodule

// File: rtl/e1map_ser.sv
module e1map_ser #(
  parameter int         SLOT_BITS = 8,
  parameter logic [7:0] IDLE_RST  = 8'hFF,
  localparam int        BIT_W     = $clog2(SLOT_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [SLOT_BITS-1:0] load_byte,
  input  logic [BIT_W-1:0]     bit_cnt,
  output logic [SLOT_BITS-1:0] cur_byte,
  output logic                 line_bit
);

  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(SLOT_BITS - 1);

  logic [SLOT_BITS-1:0] byte_d;
  logic [BIT_W-1:0]     tap;

  always_comb begin
    byte_d   = load_en ? load_byte : cur_byte;
    tap      = BIT_TOP - bit_cnt;
    line_bit = cur_byte[tap];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_byte <= SLOT_BITS'(IDLE_RST);
    else        cur_byte <= byte_d;
  end

  AST_BYTE_HELD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(cur_byte));  // R1

endmodule

// File: rtl/e1_slot_mapper.sv
module e1_slot_mapper #(
  parameter int         SLOTS     = 32,
  parameter int         SLOT_BITS = 8,
  parameter int         DEF_COUNT = 24,
  parameter int         DEF_START = 1,
  parameter logic [7:0] IDLE_RST  = 8'hFF,
  localparam int        SLOT_W    = $clog2(SLOTS),
  localparam int        BIT_W     = $clog2(SLOT_BITS),
  localparam int        CNT_W     = $clog2(SLOTS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [SLOT_W-1:0] cfg_start,
  input  logic [7:0]        cfg_idle,
  input  logic              pay_valid,
  input  logic [7:0]        pay_data,
  output logic              pay_ready,
  output logic              ser_out,
  output logic              slot0_win,
  output logic              underrun
);

  logic [BIT_W-1:0]  bit_cnt;
  logic [SLOT_W-1:0] slot_cnt;
  logic [SLOT_W-1:0] next_slot;
  logic              bit_last;
  logic [CNT_W-1:0]  count_q;
  logic [SLOT_W-1:0] start_q;
  logic [7:0]        idle_q;
  logic              structured;
  logic [7:0]        cur_byte;
  logic [7:0]        fill_byte;
  logic [CNT_W:0]    ns_ext;
  logic [CNT_W:0]    lo_ext;
  logic [CNT_W:0]    hi_ext;
  logic              next_mapped;
  logic              take;
  logic              under_d;

  e1map_pos #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) pos_i (
    .clk(clk), .rst_n(rst_n), .bit_cnt(bit_cnt), .slot_cnt(slot_cnt),
    .next_slot(next_slot), .bit_last(bit_last)
  );

  e1map_cfg #(.SLOTS(SLOTS), .DEF_COUNT(DEF_COUNT), .DEF_START(DEF_START),
              .IDLE_RST(IDLE_RST)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_count(cfg_count),
    .wr_start(cfg_start), .wr_idle(cfg_idle), .count_q(count_q),
    .start_q(start_q), .idle_q(idle_q), .structured(structured)
  );

  // Slot selection for the slot that starts at the next boundary.
  always_comb begin
    ns_ext      = (CNT_W+1)'(next_slot);
    lo_ext      = (CNT_W+1)'(start_q);
    hi_ext      = lo_ext + (CNT_W+1)'(count_q);
    next_mapped = (ns_ext >= lo_ext) && (ns_ext < hi_ext);
    pay_ready   = bit_last && next_mapped;
    take        = pay_ready && pay_valid;
    fill_byte   = take ? pay_data : idle_q;
    under_d     = pay_ready && !pay_valid;
    slot0_win   = structured && (slot_cnt == '0);
  end

  e1map_ser #(.SLOT_BITS(SLOT_BITS), .IDLE_RST(IDLE_RST)) ser_i (
    .clk(clk), .rst_n(rst_n), .load_en(bit_last), .load_byte(fill_byte),
    .bit_cnt(bit_cnt), .cur_byte(cur_byte), .line_bit(ser_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underrun <= 1'b0;
    else        underrun <= under_d;
  end

  AST_READY_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> (bit_cnt == BIT_W'(SLOT_BITS - 1)));  // R8

  AST_SLOT0_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (structured && next_slot == '0) |-> !pay_ready);  // R2

  AST_TRANSPARENT_ALL_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!structured && bit_last) |-> pay_ready);  // R3

  AST_UNDERRUN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);  // R9

  AST_UNDERRUN_SENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (cur_byte == $past(idle_q)));  // R9

  AST_WIN_IN_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    slot0_win |-> (slot_cnt == '0 && count_q < CNT_W'(SLOTS)));  // R2

endmodule

// File: tb/e1_slot_mapper_tb_top.sv
module e1_slot_mapper_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [5:0] cfg_count;
  logic [4:0] cfg_start;
  logic [7:0] cfg_idle;
  logic       pay_valid;
  logic [7:0] pay_data;
  logic       pay_ready;
  logic       ser_out;
  logic       slot0_win;
  logic       underrun;

  int checks = 0;
  int fails  = 0;

  // Bench model state
  int         m_cnt, m_start;
  logic [7:0] m_idle;
  int         bslot, bbit;
  logic [7:0] cur_byte;
  logic       exp_under;
  int         rdy_in_frame;
  logic       frame_clean;
  logic       frame_rej;

  always #5 clk = ~clk;

  e1_slot_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_count(cfg_count),
    .cfg_start(cfg_start), .cfg_idle(cfg_idle), .pay_valid(pay_valid),
    .pay_data(pay_data), .pay_ready(pay_ready), .ser_out(ser_out),
    .slot0_win(slot0_win), .underrun(underrun)
  );

  function automatic logic legal(input int c, input int s);
    return (c == 32 && s == 0) || (c >= 1 && c <= 31 && s >= 1 && s + c <= 32);
  endfunction

  function automatic logic in_run(input int slot);
    return (slot >= m_start) && (slot < m_start + m_cnt);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (slot %0d bit %0d)", tag, act, exp, bslot, bbit);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // One bit time: drive at the falling edge, check, predict the next edge.
  task automatic step(input logic v, input logic [7:0] d, input logic w,
                      input int wc, input int ws, input logic [7:0] wi);
    int         nslot;
    logic       nmap;
    logic       rdy_exp;
    logic [7:0] nxt_byte;
    logic       nxt_under;
    string      tag;
    pay_valid = v;
    pay_data  = d;
    cfg_wr    = w;
    cfg_count = 6'(wc);
    cfg_start = 5'(ws);
    cfg_idle  = wi;
    #1;
    nslot   = (bslot + 1) % 32;
    nmap    = in_run(nslot);
    rdy_exp = (bbit == 7) && nmap;
    if (m_cnt < 32 && bslot == 0) tag = "R2";
    else if (!in_run(bslot))      tag = "R4";
    else if (exp_under)           tag = "R9";
    else                          tag = "R6";
    chk(ser_out, cur_byte[7 - bbit], tag);
    chk(slot0_win, (m_cnt < 32) && (bslot == 0), (m_cnt < 32) ? "R2" : "R3");
    chk(pay_ready, rdy_exp, w ? "R10" : "R8");
    chk(underrun, exp_under, "R9");
    nxt_byte  = cur_byte;
    nxt_under = 1'b0;
    if (bbit == 7) begin
      nxt_byte  = (nmap && v) ? d : m_idle;
      nxt_under = nmap && !v;
    end
    if (rdy_exp) rdy_in_frame++;
    // R10: settings change after the decisions of this edge; R7: refused writes ignored
    if (w) begin
      if (legal(wc, ws)) begin
        m_cnt = wc; m_start = ws; m_idle = wi; frame_clean = 1'b0;
      end else begin
        frame_rej = 1'b1;
      end
    end
    @(posedge clk);
    cur_byte  = nxt_byte;
    exp_under = nxt_under;
    if (bbit == 7) begin
      bbit  = 0;
      bslot = nslot;
      if (bslot == 0) begin
        if (frame_clean) chk_int(rdy_in_frame, m_cnt, frame_rej ? "R7" : "R5");
        rdy_in_frame = 0;
        frame_clean  = 1'b1;
        frame_rej    = 1'b0;
      end
    end else begin
      bbit++;
    end
    @(negedge clk);
  endtask

  task automatic run(input int n, input int pct);
    for (int i = 0; i < n; i++)
      step(($urandom % 100) < pct, 8'($urandom), 1'b0, 0, 0, 8'h00);
  endtask

  task automatic wcfg(input int c, input int s, input logic [7:0] i);
    step(1'b1, 8'($urandom), 1'b1, c, s, i);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_count = '0; cfg_start = '0; cfg_idle = '0;
    pay_valid = 1'b0; pay_data = '0;
    m_cnt = 24; m_start = 1; m_idle = 8'hFF;
    bslot = 0; bbit = 0; cur_byte = 8'hFF; exp_under = 1'b0;
    rdy_in_frame = 0; frame_clean = 1'b1; frame_rej = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 / R4: reset state, slot 0 bit 7 of idle 0xFF, default structured run
    chk(ser_out, 1'b1, "R1");
    chk(slot0_win, 1'b1, "R1");
    chk(pay_ready, 1'b0, "R1");
    chk(underrun, 1'b0, "R4");
    #0;
    // default 24 slots from slot 1, source always ready
    run(3 * 256, 100);
    // stalls give underruns
    run(2 * 256, 50);
    // transparent full frame
    run(13, 80);
    wcfg(32, 0, 8'h55);
    run(3 * 256, 90);
    // refused writes keep the full frame
    wcfg(32, 1, 8'h00);
    wcfg(0, 0, 8'h0F);
    wcfg(33, 0, 8'h11);
    run(2 * 256, 100);
    // run that ends at the last slot
    wcfg(8, 24, 8'hA5);
    run(2 * 256, 70);
    // single slot at the top
    wcfg(1, 31, 8'h3C);
    run(2 * 256, 100);
    // refused: overflow past slot 31, structured run on slot 0
    wcfg(8, 25, 8'h00);
    wcfg(5, 0, 8'h00);
    run(2 * 256, 100);
    // random configurations and stall patterns
    for (int r = 0; r < 25; r++) begin
      run($urandom % 256, 75);
      wcfg($urandom % 34, $urandom % 32, 8'($urandom));
      run(256 + ($urandom % 256), $urandom % 101);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule